// File: doc/BRIEF.md
# PHY Control Register Bank with Embedded Write Masks

This block is a small bank of 32-bit control registers that sits between a simple single-cycle bus port and a PHY. Every bus write carries its own enable mask. The upper half of the written word selects which of the lower sixteen bits are updated. Software can therefore set or clear a single field without first reading the register back.

One register drives a PHY configuration port. Its fields are a write strobe, a 6-bit configuration address and a 4-bit configuration value. When the stored strobe bit goes from 0 to 1, the block emits a single-cycle write pulse. The address and value fields appear on dedicated outputs.

A second register holds one idle control per lane. A third offset is read-only and returns the live PLL lock and PLL output indications from the PHY. Reads are combinational from the selected offset.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a writable offset, lower bit x changes to wdata bit x only when wdata bit x+16 is 1; every lower bit whose enable is 0 keeps its value.
- R2: Bits 31:16 of read data are always 0.
- R3: In the configuration register (word offset 0), bit 0 is the strobe, bits 6:1 drive the 6-bit configuration address output and bits 10:7 drive the 4-bit configuration value output.
- R4: A rising edge of the stored strobe bit produces a configuration write pulse that is high for exactly the one cycle after the updating write edge. Address and value outputs hold the stored fields during the pulse.
- R5: Writing the strobe bit as 1 while it is already 1, or changing other fields while it stays 1, produces no pulse.
- R6: In the lane register (word offset 1), bits 3, 4, 5 and 6 are the idle controls of lanes 0 to 3, with 1 meaning idle. They appear on the lane idle output, lane 0 in bit 0.
- R7: Reading the status offset (word offset 2) returns the live PLL-lock input in bit 9 and the live PLL-output input in bit 10, with all other bits 0.
- R8: Writes to the status offset or to the unused offset 3 change no stored state and no output.
- R9: Synchronous active-low reset clears all writable bits and the strobe history, so no pulse is produced during or just after reset.
- R10: Reading offset 3 returns 0. Reading offsets 0 and 1 returns the stored lower sixteen bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| addr_i | input | ADDR_W (2) | Word offset for read and write |
| wdata_i | input | DATA_W (32) | Write word: enables in the upper half, data in the lower half |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| pll_locked_i | input | 1 | PLL lock indication from the PHY |
| pll_output_i | input | 1 | PLL output state from the PHY |
| cfg_wr_pulse_o | output | 1 | One-cycle PHY configuration write pulse |
| cfg_wr_addr_o | output | 6 | PHY configuration address field |
| cfg_wr_data_o | output | 4 | PHY configuration value field |
| lane_idle_o | output | NUM_LANES (4) | Per-lane idle controls |

## Verification
The assertions assume the bus holds wr_en, addr_i and wdata_i stable across each clock edge. They also assume the PLL inputs are already synchronous to clk, since the status read path is purely combinational. The bench drives every input on the falling edge and samples outputs half a period later, which keeps it within both assumptions. It covers writes with full, partial and empty enable masks, repeated strobe writes, writes to the read-only and unused offsets, a reset taken while the strobe is high, and a long pseudo-random mix of offsets, masks and PLL input values.

// File: rtl/phy_ctl_regbank_pkg.sv
// Package: shared offsets and field positions for the PHY control register bank.
// Assumes word addressing; field positions are fixed by the PHY-side decode.
package phy_ctl_regbank_pkg;

    // word offsets of the registers
    localparam int REG_CFG  = 0;
    localparam int REG_LANE = 1;
    localparam int REG_STAT = 2;

    // configuration register fields
    localparam int CFG_STB_BIT  = 0;
    localparam int CFG_ADDR_LSB = 1;
    localparam int CFG_ADDR_W   = 6;
    localparam int CFG_DATA_LSB = 7;
    localparam int CFG_DATA_W   = 4;

    // lane register: first idle bit, one bit per lane upward
    localparam int LANE_IDLE_LSB = 3;

    // status register bits
    localparam int STAT_LOCK_BIT = 9;
    localparam int STAT_OUT_BIT  = 10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_LANE,
        SEL_STAT
    } reg_sel_e;

endpackage

// File: rtl/regbank_masked_reg.sv
// Module: one storage register updated through an embedded per-bit enable.
// The upper HALF_W bits of wdata_i enable the matching lower HALF_W data bits.
// Assumes wr_i is already qualified by the offset decode.
module regbank_masked_reg #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [2*HALF_W-1:0]   wdata_i,
    output logic [HALF_W-1:0]     q_o
);

    logic [HALF_W-1:0] bit_en;
    logic [HALF_W-1:0] q_next;

    assign bit_en = wdata_i[2*HALF_W-1:HALF_W];

    // merge enabled new bits with retained old bits
    always_comb begin
        q_next = (q_o & ~bit_en) | (wdata_i[HALF_W-1:0] & bit_en);
    end

    // storage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (wr_i) begin
            q_o <= q_next;
        end
    end

    // R1: bits without an enable keep their value across a write
    p_masked_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((q_o & ~$past(bit_en)) == ($past(q_o) & ~$past(bit_en))));

    // R1: enabled bits take the written data
    p_masked_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((q_o & $past(bit_en)) == ($past(wdata_i[HALF_W-1:0]) & $past(bit_en))));

endmodule

// File: rtl/regbank_cfg_strobe.sv
// Module: turns the stored strobe level into a single-cycle configuration pulse.
// It remembers the strobe of the previous cycle, and fields pass straight through.
// Assumes stb_i comes from a register, so the pulse is free of glitches.
module regbank_cfg_strobe #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pulse_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    logic stb_prev;

    // remember the strobe level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_prev <= 1'b0;
        end else begin
            stb_prev <= stb_i;
        end
    end

    // pulse on a 0 to 1 transition; fields follow the stored register
    always_comb begin
        pulse_o = stb_i & ~stb_prev;
        addr_o  = addr_i;
        data_o  = data_i;
    end

    // R4: the pulse never lasts two cycles
    p_pulse_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/regbank_rdmux.sv
// Module: builds read data for the selected register.
// The upper half is always zero and status bits come live from the PHY inputs.
// Assumes pll inputs are synchronous to the bus clock.
module regbank_rdmux
    import phy_ctl_regbank_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  reg_sel_e          sel_i,
    input  logic [HALF_W-1:0] cfg_q_i,
    input  logic [HALF_W-1:0] lane_q_i,
    input  logic              pll_locked_i,
    input  logic              pll_output_i,
    output logic [2*HALF_W-1:0] rdata_o
);

    logic [HALF_W-1:0] stat_word;
    logic [HALF_W-1:0] low_word;

    // assemble the live status word
    always_comb begin
        stat_word                = '0;
        stat_word[STAT_LOCK_BIT] = pll_locked_i;
        stat_word[STAT_OUT_BIT]  = pll_output_i;
    end

    // select the lower half by register
    always_comb begin
        unique case (sel_i)
            SEL_CFG:  low_word = cfg_q_i;
            SEL_LANE: low_word = lane_q_i;
            SEL_STAT: low_word = stat_word;
            default:  low_word = '0;
        endcase
        rdata_o = {{HALF_W{1'b0}}, low_word};
    end

endmodule

// File: rtl/phy_ctl_regbank.sv
// Module: PHY control register bank top.
// It decodes the word offset, applies masked writes to the configuration and
// lane registers, drives the PHY configuration port and lane idles, and returns
// read data. Assumes bus inputs are stable around each rising clock edge.
module phy_ctl_regbank
    import phy_ctl_regbank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int NUM_LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    input  logic                  pll_locked_i,
    input  logic                  pll_output_i,
    output logic                  cfg_wr_pulse_o,
    output logic [CFG_ADDR_W-1:0] cfg_wr_addr_o,
    output logic [CFG_DATA_W-1:0] cfg_wr_data_o,
    output logic [NUM_LANES-1:0]  lane_idle_o
);

    localparam int HALF_W = DATA_W / 2;

    reg_sel_e          sel;
    logic              wr_cfg;
    logic              wr_lane;
    logic [HALF_W-1:0] cfg_q;
    logic [HALF_W-1:0] lane_q;

    // offset decode
    always_comb begin
        if (addr_i == ADDR_W'(REG_CFG)) begin
            sel = SEL_CFG;
        end else if (addr_i == ADDR_W'(REG_LANE)) begin
            sel = SEL_LANE;
        end else if (addr_i == ADDR_W'(REG_STAT)) begin
            sel = SEL_STAT;
        end else begin
            sel = SEL_NONE;
        end
    end

    // write qualification: only the two writable registers accept writes
    always_comb begin
        wr_cfg  = wr_en && (sel == SEL_CFG);
        wr_lane = wr_en && (sel == SEL_LANE);
    end

    regbank_masked_reg #(.HALF_W(HALF_W)) u_cfg_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_cfg),
        .wdata_i (wdata_i),
        .q_o     (cfg_q)
    );

    regbank_masked_reg #(.HALF_W(HALF_W)) u_lane_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_lane),
        .wdata_i (wdata_i),
        .q_o     (lane_q)
    );

    regbank_cfg_strobe #(.ADDR_W(CFG_ADDR_W), .DATA_W(CFG_DATA_W)) u_cfg_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (cfg_q[CFG_STB_BIT]),
        .addr_i  (cfg_q[CFG_ADDR_LSB +: CFG_ADDR_W]),
        .data_i  (cfg_q[CFG_DATA_LSB +: CFG_DATA_W]),
        .pulse_o (cfg_wr_pulse_o),
        .addr_o  (cfg_wr_addr_o),
        .data_o  (cfg_wr_data_o)
    );

    // one idle output per lane, taken from consecutive lane register bits
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_idle_o[g] = lane_q[LANE_IDLE_LSB + g];
    end

    regbank_rdmux #(.HALF_W(HALF_W)) u_rdmux (
        .sel_i        (sel),
        .cfg_q_i      (cfg_q),
        .lane_q_i     (lane_q),
        .pll_locked_i (pll_locked_i),
        .pll_output_i (pll_output_i),
        .rdata_o      (rdata_o)
    );

    // R4: a pulse follows a config-offset write that enabled and set the strobe
    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_pulse_o |-> $past(wr_en && addr_i == ADDR_W'(REG_CFG)
                                 && wdata_i[HALF_W + CFG_STB_BIT] && wdata_i[CFG_STB_BIT]));

    // R8: a write to the read-only status offset leaves the port outputs alone
    p_status_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_i == ADDR_W'(REG_STAT)) |=>
            ($stable(lane_idle_o) && $stable(cfg_wr_addr_o) && $stable(cfg_wr_data_o)
             && !cfg_wr_pulse_o));

endmodule

// File: tb/phy_ctl_regbank_tb.sv
`timescale 1ns/1ps
module phy_ctl_regbank_tb;

    localparam int DW = 32;
    localparam int AW = 2;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          pll_locked = 1'b0;
    logic          pll_output = 1'b0;
    logic [DW-1:0] rdata;
    logic          pulse;
    logic [5:0]    cfg_addr;
    logic [3:0]    cfg_data;
    logic [NL-1:0] lane_idle;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // behavioural model state
    logic [15:0] m_cfg  = '0;
    logic [15:0] m_lane = '0;
    logic        m_pulse = 1'b0;

    phy_ctl_regbank #(.DATA_W(DW), .ADDR_W(AW), .NUM_LANES(NL)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .pll_locked_i   (pll_locked),
        .pll_output_i   (pll_output),
        .cfg_wr_pulse_o (pulse),
        .cfg_wr_addr_o  (cfg_addr),
        .cfg_wr_data_o  (cfg_data),
        .lane_idle_o    (lane_idle)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            2'd0: r[15:0] = m_cfg;
            2'd1: r[15:0] = m_lane;
            2'd2: begin r[9] = pll_locked; r[10] = pll_output; end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string rtag(logic [AW-1:0] a);
        case (a)
            2'd0, 2'd1: return "R1";
            2'd2:       return "R7";
            default:    return "R10";
        endcase
    endfunction

    // one bus cycle: drive at the falling edge, check reads, step the model, check outputs
    task automatic cycle(bit w, logic [AW-1:0] a, logic [31:0] d, string tag);
        logic        old_stb;
        logic [15:0] msk;
        wr_en = w;
        addr  = a;
        wdata = d;
        #1;
        chk(rtag(a), "rdata", rdata, exp_read(a));
        chk("R2", "rdata upper half", {16'h0, rdata[31:16]}, 32'h0);
        @(posedge clk);
        old_stb = m_cfg[0];
        msk     = d[31:16];
        if (!rst_n) begin
            m_cfg  = '0;
            m_lane = '0;
        end else if (w && a == 2'd0) begin
            m_cfg = (m_cfg & ~msk) | (d[15:0] & msk);
        end else if (w && a == 2'd1) begin
            m_lane = (m_lane & ~msk) | (d[15:0] & msk);
        end
        m_pulse = rst_n && m_cfg[0] && !old_stb;
        @(negedge clk);
        chk(tag, "cfg pulse", {31'h0, pulse}, {31'h0, m_pulse});
        chk(tag, "cfg addr field", {26'h0, cfg_addr}, {26'h0, m_cfg[6:1]});
        chk(tag, "cfg data field", {28'h0, cfg_data}, {28'h0, m_cfg[10:7]});
        chk(tag, "lane idle", {28'h0, lane_idle}, {28'h0, m_lane[6:3]});
    endtask

    function automatic logic [31:0] cfg_word(logic [15:0] en, logic [3:0] dv, logic [5:0] av, logic s);
        return {en, 5'h0, dv, av, s};
    endfunction

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h1234_5678;
        @(posedge clk);
        @(negedge clk);
        // R9: reset state, with a write attempt held off by reset
        cycle(1'b1, 2'd0, 32'hFFFF_FFFF, "R9");
        cycle(1'b0, 2'd0, 32'h0, "R9");
        rst_n = 1'b1;
        cycle(1'b0, 2'd0, 32'h0, "R9");
        cycle(1'b0, 2'd1, 32'h0, "R9");

        // R3: load address 0x25 and value 0x9 with the strobe low
        cycle(1'b1, 2'd0, cfg_word(16'hFFFF, 4'h9, 6'h25, 1'b0), "R3");
        cycle(1'b0, 2'd0, 32'h0, "R3");
        // R4: set only the strobe, expect one pulse then none
        cycle(1'b1, 2'd0, 32'h0001_0001, "R4");
        cycle(1'b0, 2'd0, 32'h0, "R4");
        cycle(1'b0, 2'd0, 32'h0, "R4");
        // R5: strobe rewritten as 1, then fields changed with strobe held high
        cycle(1'b1, 2'd0, 32'h0001_0001, "R5");
        cycle(1'b1, 2'd0, cfg_word(16'h007E, 4'h0, 6'h0A, 1'b0), "R5");
        cycle(1'b1, 2'd0, cfg_word(16'h07FF, 4'h3, 6'h11, 1'b1), "R5");
        // R1: clear the strobe and change the value field only
        cycle(1'b1, 2'd0, cfg_word(16'h0781, 4'hC, 6'h3F, 1'b0), "R1");
        // R1: empty mask changes nothing
        cycle(1'b1, 2'd0, 32'h0000_FFFF, "R1");
        // R4: strobe and new address in the same write give a pulse
        cycle(1'b1, 2'd0, cfg_word(16'h007F, 4'h0, 6'h2A, 1'b1), "R4");
        cycle(1'b0, 2'd1, 32'h0, "R4");

        // R6: lane idle bits one at a time and in groups
        cycle(1'b1, 2'd1, 32'h0008_0008, "R6");
        cycle(1'b1, 2'd1, 32'h0030_0030, "R6");
        cycle(1'b1, 2'd1, 32'h0048_0040, "R6");
        cycle(1'b1, 2'd1, 32'h0078_0000, "R6");
        // R2: set every bit with full mask, upper half must read zero
        cycle(1'b1, 2'd1, 32'hFFFF_FFFF, "R2");
        cycle(1'b0, 2'd1, 32'h0, "R2");

        // R7: status read for every pll input combination
        for (int k = 0; k < 4; k++) begin
            pll_locked = k[0];
            pll_output = k[1];
            cycle(1'b0, 2'd2, 32'h0, "R7");
        end

        // R8: writes to the status and unused offsets change nothing
        cycle(1'b1, 2'd0, 32'h0001_0000, "R8");
        cycle(1'b1, 2'd2, 32'hFFFF_FFFF, "R8");
        cycle(1'b1, 2'd3, 32'hFFFF_FFFF, "R8");
        cycle(1'b0, 2'd0, 32'h0, "R8");
        cycle(1'b0, 2'd3, 32'h0, "R10");

        // R9: reset while the strobe is high, then a fresh strobe write pulses
        cycle(1'b1, 2'd0, 32'h0001_0001, "R9");
        rst_n = 1'b0;
        cycle(1'b0, 2'd0, 32'h0, "R9");
        rst_n = 1'b1;
        cycle(1'b0, 2'd1, 32'h0, "R9");
        cycle(1'b1, 2'd0, 32'h0001_0001, "R9");
        cycle(1'b0, 2'd0, 32'h0, "R9");

        // R1: pseudo-random mix of offsets, masks and pll values
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rw;
            seed = seed * 32'd1103515245 + 32'd12345;
            rw   = seed;
            seed = seed * 32'd1103515245 + 32'd12345;
            pll_locked = seed[20];
            pll_output = seed[21];
            cycle(seed[16], seed[18:17], rw, "R1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule